// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block is the command engine of a byte-level I2C master. Software programs a transmit byte and then writes a command word whose low bits ask for any mix of four phases: an addressing start, a data send, a data receive and a stop. The engine runs the requested phases one after another in a fixed order. It drives a byte-level bus interface with one operation at a time: begin transfer with an address byte, send a byte, receive a byte, or end the transfer. It waits for that interface's completion pulse before it moves on.

While it runs, the engine tracks a small master state and whether a transfer is active. It records each outcome in sticky, write-one-to-clear status bits, and it raises a registered interrupt when an enabled status bit is set. A start issued while a transfer is active becomes a repeated start. A stop issued with no active transfer is flagged as abnormal and does not touch the bus.

Register map (word address): 0 command, 1 data buffer, 2 interrupt enable, 3 status. Reads return the addressed register one cycle after the address is presented.

Top module: `i2c_cmd_seq`

## Requirements
- R1: After reset the command, buffer, interrupt-enable and status registers read as zero, the master state reads 0 (idle), `irq` is low and `bus_req` is low.
- R2: A command write (address 0) stores only bits [15:0]. Readback bits [18:16] always show the master state (0 idle, 1 start, 2 repeated start, 3 active, 4 sending, 5 receiving, 6 stopping), and a write cannot change them. A command write is ignored while any phase bit [4:0] is pending or a bus operation is outstanding.
- R3: Command bits are START=bit0, TX=bit1, RX=bit2, RXLAST=bit3 and STOP=bit4. Pending phases run in the order START, TX, RX, STOP, with exactly one bus operation outstanding at a time (`bus_req` held with a stable `bus_op` until `bus_done`). Each bit clears when its phase completes.
- R4: A START issues `bus_op`=0 with `bus_wdata` = buffer bits [7:0] (address in [7:1], direction in bit 0). The state is 2 if a transfer is already active, and 1 otherwise. START clears the TX bit as well, so no separate send follows.
- R5: An acknowledged address sets status TXACK (bit 0) and enters state 3 with the transfer active. A refused address sets TXNAK (bit 1), clears every pending command bit, returns to state 0 and issues no further operation.
- R6: A TX issues `bus_op`=1 with the buffer byte. An ACK sets TXACK and returns to state 3. A NAK sets TXNAK, clears all pending bits and issues an end operation (`bus_op`=3) without setting a stop status. A TX with no active transfer sets TXNAK and issues no operation.
- R7: An RX (bit 2 or bit 3) issues `bus_op`=2 with `bus_last` equal to bit 3. The received byte lands in buffer bits [15:8] and RXDONE (status bit 2) is set. An RX, and every phase behind it, waits while RXDONE is set.
- R8: A STOP with an active transfer issues `bus_op`=3 and then sets NSTOP (status bit 3). A STOP with no active transfer sets ASTOP (status bit 4) and issues no operation. Either way the state returns to 0.
- R9: Status bits are cleared by writing 1 to them at address 3. Writing 0 leaves a bit unchanged.
- R10: `irq` is the registered OR of status bits ANDed with the interrupt-enable register bits [4:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Register write word address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 2 | Register read word address |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |
| bus_req | output | 1 | Bus operation request, held until done |
| bus_op | output | 2 | Operation: 0 begin+address, 1 send, 2 receive, 3 end |
| bus_wdata | output | 8 | Byte for begin or send |
| bus_last | output | 1 | Receive is the last byte |
| bus_done | input | 1 | One-cycle completion of the requested operation |
| bus_nak | input | 1 | Completion was not acknowledged (valid with done) |
| bus_rdata | input | 8 | Received byte (valid with done) |

## Verification
The hardest case to reach is a receive that is held back because RXDONE is still set from an earlier byte, with a stop queued behind it. From the ports, this needs a completed receive whose status is left uncleared, and then a new start-receive-stop command. The bench builds this state, waits many cycles to show that no bus operation appears and that a second command write bounces off the pending bits, and then releases the queue by clearing RXDONE. Repeated start, address refusal and data refusal are also reached only through sequences that first open a transfer, so each one is staged by an earlier command in the same run.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int CMD_W      = 5;
  localparam int CMD_START  = 0;
  localparam int CMD_TX     = 1;
  localparam int CMD_RX     = 2;
  localparam int CMD_RXLAST = 3;
  localparam int CMD_STOP   = 4;

  localparam int ST_W      = 5;
  localparam int ST_TXACK  = 0;
  localparam int ST_TXNAK  = 1;
  localparam int ST_RXDONE = 2;
  localparam int ST_NSTOP  = 3;
  localparam int ST_ASTOP  = 4;

  localparam logic [1:0] RA_CMD  = 2'd0;
  localparam logic [1:0] RA_BUF  = 2'd1;
  localparam logic [1:0] RA_IEN  = 2'd2;
  localparam logic [1:0] RA_STAT = 2'd3;

  typedef enum logic [1:0] {
    BOP_BEGIN = 2'd0,
    BOP_SEND  = 2'd1,
    BOP_RECV  = 2'd2,
    BOP_END   = 2'd3
  } bus_op_e;

  typedef enum logic [2:0] {
    MS_IDLE   = 3'd0,
    MS_START  = 3'd1,
    MS_RSTART = 3'd2,
    MS_ACTIVE = 3'd3,
    MS_TXD    = 3'd4,
    MS_RXD    = 3'd5,
    MS_STOP   = 3'd6
  } mstate_e;

  typedef enum logic [2:0] {
    PH_NONE  = 3'd0,
    PH_START = 3'd1,
    PH_TX    = 3'd2,
    PH_RX    = 3'd3,
    PH_STOP  = 3'd4,
    PH_END   = 3'd5
  } phase_e;
endpackage

// File: rtl/i2cs_regs.sv
module i2cs_regs
  import i2cs_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 2,
  parameter int BYTE_W = 8,
  parameter int KEEP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic              seq_wait,
  input  logic [CMD_W-1:0]  cmd_clr,
  input  logic [ST_W-1:0]   st_set,
  input  logic              rx_load,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [2:0]        mstate,
  output logic [CMD_W-1:0]  cmd_bits,
  output logic [BYTE_W-1:0] tx_byte,
  output logic [ST_W-1:0]   ien,
  output logic [ST_W-1:0]   status
);
  localparam int PAD_CMD = REG_W - KEEP_W - 3;
  localparam int PAD_BUF = REG_W - 2 * BYTE_W;
  localparam int PAD_ST  = REG_W - ST_W;

  logic [KEEP_W-1:0] cmd_q;
  logic [BYTE_W-1:0] tx_q, rx_q;
  logic [ST_W-1:0]   ien_q, st_q;
  logic              busy;
  logic              cmd_take;
  logic [ST_W-1:0]   w1c;
  logic              wdata_unused;

  assign wdata_unused = ^wr_data[REG_W-1:KEEP_W];
  assign busy     = seq_wait | (|cmd_q[CMD_W-1:0]);
  assign cmd_take = wr_en && (wr_addr == RA_CMD) && !busy;
  assign w1c      = (wr_en && (wr_addr == RA_STAT)) ? wr_data[ST_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      tx_q  <= '0;
      rx_q  <= '0;
      ien_q <= '0;
      st_q  <= '0;
    end else begin
      if (cmd_take) cmd_q <= wr_data[KEEP_W-1:0];
      else          cmd_q[CMD_W-1:0] <= cmd_q[CMD_W-1:0] & ~cmd_clr;
      if (wr_en && (wr_addr == RA_BUF)) tx_q <= wr_data[BYTE_W-1:0];
      if (rx_load) rx_q <= rx_byte;
      if (wr_en && (wr_addr == RA_IEN)) ien_q <= wr_data[ST_W-1:0];
      st_q <= (st_q & ~w1c) | st_set;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_addr)
        RA_CMD:  rd_data <= {{PAD_CMD{1'b0}}, mstate, cmd_q};
        RA_BUF:  rd_data <= {{PAD_BUF{1'b0}}, rx_q, tx_q};
        RA_IEN:  rd_data <= {{PAD_ST{1'b0}}, ien_q};
        default: rd_data <= {{PAD_ST{1'b0}}, st_q};
      endcase
    end
  end

  assign cmd_bits = cmd_q[CMD_W-1:0];
  assign tx_byte  = tx_q;
  assign ien      = ien_q;
  assign status   = st_q;

  // R9: a set status bit survives any cycle in which software did not write 1 to it
  a_r9_w1c_hold: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(st_q) & ~$past(w1c)) & ~st_q) == '0));

  // R2: a command write refused while busy leaves the stored upper command bits intact
  a_r2_busy_ignore: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_addr == RA_CMD) && busy) |=> (cmd_q[KEEP_W-1:CMD_W] == $past(cmd_q[KEEP_W-1:CMD_W])));
endmodule

// File: rtl/i2cs_seq.sv
module i2cs_seq
  import i2cs_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CMD_W-1:0]  cmd_bits,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              rxdone,
  input  logic              bus_done,
  input  logic              bus_nak,
  input  logic [BYTE_W-1:0] bus_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_op,
  output logic [BYTE_W-1:0] bus_wdata,
  output logic              bus_last,
  output logic              seq_wait,
  output logic [CMD_W-1:0]  cmd_clr,
  output logic [ST_W-1:0]   st_set,
  output logic              rx_load,
  output logic [BYTE_W-1:0] rx_byte,
  output logic [2:0]        mstate
);
  localparam logic [CMD_W-1:0] CLR_ALL = '1;

  logic              wait_q, end_pend_q, active_q;
  phase_e            phase_q;
  mstate_e           ms_q;
  bus_op_e           op_q;

  logic              iss;
  phase_e            iss_ph;
  bus_op_e           iss_op;
  mstate_e           iss_ms;
  logic [BYTE_W-1:0] iss_data;
  logic              iss_last;
  logic              fin;

  assign fin = wait_q && bus_done;

  always_comb begin
    cmd_clr  = '0;
    st_set   = '0;
    rx_load  = 1'b0;
    iss      = 1'b0;
    iss_ph   = PH_NONE;
    iss_op   = BOP_END;
    iss_ms   = ms_q;
    iss_data = '0;
    iss_last = 1'b0;
    if (wait_q) begin
      if (bus_done) begin
        case (phase_q)
          PH_START: begin
            cmd_clr[CMD_START] = 1'b1;
            cmd_clr[CMD_TX]    = 1'b1;
            if (bus_nak) begin
              st_set[ST_TXNAK] = 1'b1;
              cmd_clr          = CLR_ALL;
            end else begin
              st_set[ST_TXACK] = 1'b1;
            end
          end
          PH_TX: begin
            cmd_clr[CMD_TX] = 1'b1;
            if (bus_nak) begin
              st_set[ST_TXNAK] = 1'b1;
              cmd_clr          = CLR_ALL;
            end else begin
              st_set[ST_TXACK] = 1'b1;
            end
          end
          PH_RX: begin
            cmd_clr[CMD_RX]     = 1'b1;
            cmd_clr[CMD_RXLAST] = 1'b1;
            st_set[ST_RXDONE]   = 1'b1;
            rx_load             = 1'b1;
          end
          PH_STOP: begin
            cmd_clr[CMD_STOP] = 1'b1;
            st_set[ST_NSTOP]  = 1'b1;
          end
          default: ;
        endcase
      end
    end else if (end_pend_q) begin
      iss    = 1'b1;
      iss_ph = PH_END;
      iss_op = BOP_END;
      iss_ms = MS_STOP;
    end else if (cmd_bits[CMD_START]) begin
      iss      = 1'b1;
      iss_ph   = PH_START;
      iss_op   = BOP_BEGIN;
      iss_ms   = active_q ? MS_RSTART : MS_START;
      iss_data = tx_byte;
    end else if (cmd_bits[CMD_TX]) begin
      if (active_q) begin
        iss      = 1'b1;
        iss_ph   = PH_TX;
        iss_op   = BOP_SEND;
        iss_ms   = MS_TXD;
        iss_data = tx_byte;
      end else begin
        st_set[ST_TXNAK] = 1'b1;
        cmd_clr          = CLR_ALL;
      end
    end else if (cmd_bits[CMD_RX] || cmd_bits[CMD_RXLAST]) begin
      if (!rxdone) begin
        iss      = 1'b1;
        iss_ph   = PH_RX;
        iss_op   = BOP_RECV;
        iss_ms   = MS_RXD;
        iss_last = cmd_bits[CMD_RXLAST];
      end
    end else if (cmd_bits[CMD_STOP]) begin
      if (active_q) begin
        iss    = 1'b1;
        iss_ph = PH_STOP;
        iss_op = BOP_END;
        iss_ms = MS_STOP;
      end else begin
        st_set[ST_ASTOP]  = 1'b1;
        cmd_clr[CMD_STOP] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_q     <= 1'b0;
      end_pend_q <= 1'b0;
      active_q   <= 1'b0;
      phase_q    <= PH_NONE;
      ms_q       <= MS_IDLE;
      op_q       <= BOP_BEGIN;
      bus_req    <= 1'b0;
      bus_wdata  <= '0;
      bus_last   <= 1'b0;
    end else if (iss) begin
      bus_req   <= 1'b1;
      op_q      <= iss_op;
      bus_wdata <= iss_data;
      bus_last  <= iss_last;
      wait_q    <= 1'b1;
      phase_q   <= iss_ph;
      ms_q      <= iss_ms;
      if (iss_ph == PH_END) end_pend_q <= 1'b0;
    end else if (fin) begin
      bus_req <= 1'b0;
      wait_q  <= 1'b0;
      phase_q <= PH_NONE;
      case (phase_q)
        PH_START: begin
          active_q <= !bus_nak;
          ms_q     <= bus_nak ? MS_IDLE : MS_ACTIVE;
        end
        PH_TX: begin
          if (bus_nak) end_pend_q <= 1'b1;
          else         ms_q       <= MS_ACTIVE;
        end
        PH_RX: ms_q <= MS_ACTIVE;
        default: begin
          active_q <= 1'b0;
          ms_q     <= MS_IDLE;
        end
      endcase
    end else if (st_set[ST_ASTOP]) begin
      ms_q <= MS_IDLE;
    end
  end

  assign bus_op   = op_q;
  assign seq_wait = wait_q | end_pend_q;
  assign rx_byte  = bus_rdata;
  assign mstate   = ms_q;

  // R3: a request is held with a stable operation until the interface completes it
  a_r3_req_hold: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_done) |=> (bus_req && $stable(bus_op)));

  // R7: a receive is only ever launched while RXDONE was clear
  a_r7_rx_gate: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_req) && (bus_op == BOP_RECV)) |-> !$past(rxdone));

  // R8: the abnormal-stop flag is raised only with no active transfer
  a_r8_astop_idle: assert property (@(posedge clk) disable iff (rst)
    st_set[ST_ASTOP] |-> !active_q);

  // R5: a refused address drops the request and returns the state to idle
  a_r5_nak_abandon: assert property (@(posedge clk) disable iff (rst)
    (wait_q && bus_done && (phase_q == PH_START) && bus_nak) |=> (ms_q == MS_IDLE && !bus_req));
endmodule

// File: rtl/i2cs_irq.sv
module i2cs_irq #(
  parameter int ST_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ST_W-1:0] status,
  input  logic [ST_W-1:0] ien,
  output logic            irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(status & ien);
  end

  // R10: the interrupt follows the enabled status of the previous cycle
  a_r10_irq_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == (|($past(status) & $past(ien)))));
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2cs_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 2,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_waddr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic [ADDR_W-1:0] reg_raddr,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq,
  output logic              bus_req,
  output logic [1:0]        bus_op,
  output logic [BYTE_W-1:0] bus_wdata,
  output logic              bus_last,
  input  logic              bus_done,
  input  logic              bus_nak,
  input  logic [BYTE_W-1:0] bus_rdata
);
  logic [CMD_W-1:0]  cmd_bits, cmd_clr;
  logic [ST_W-1:0]   st_set, ien, status;
  logic [BYTE_W-1:0] tx_byte, rx_byte;
  logic              seq_wait, rx_load;
  logic [2:0]        mstate;

  i2cs_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(reg_wr), .wr_addr(reg_waddr), .wr_data(reg_wdata),
    .rd_addr(reg_raddr), .rd_data(reg_rdata),
    .seq_wait(seq_wait), .cmd_clr(cmd_clr), .st_set(st_set),
    .rx_load(rx_load), .rx_byte(rx_byte), .mstate(mstate),
    .cmd_bits(cmd_bits), .tx_byte(tx_byte), .ien(ien), .status(status)
  );

  i2cs_seq #(.BYTE_W(BYTE_W)) u_seq (
    .clk(clk), .rst(rst),
    .cmd_bits(cmd_bits), .tx_byte(tx_byte), .rxdone(status[ST_RXDONE]),
    .bus_done(bus_done), .bus_nak(bus_nak), .bus_rdata(bus_rdata),
    .bus_req(bus_req), .bus_op(bus_op), .bus_wdata(bus_wdata), .bus_last(bus_last),
    .seq_wait(seq_wait), .cmd_clr(cmd_clr), .st_set(st_set),
    .rx_load(rx_load), .rx_byte(rx_byte), .mstate(mstate)
  );

  i2cs_irq #(.ST_W(ST_W)) u_irq (
    .clk(clk), .rst(rst), .status(status), .ien(ien), .irq(irq)
  );
endmodule

// File: tb/i2c_cmd_seq_tb.sv
module i2c_cmd_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [1:0]  reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        bus_req;
  logic [1:0]  bus_op;
  logic [7:0]  bus_wdata;
  logic        bus_last;
  logic        bus_done = 1'b0;
  logic        bus_nak = 1'b0;
  logic [7:0]  bus_rdata = '0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [10:0] exp_q[$];
  logic [8:0]  rsp_q[$];

  always #2.5 clk = ~clk;

  i2c_cmd_seq u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .irq(irq),
    .bus_req(bus_req), .bus_op(bus_op), .bus_wdata(bus_wdata), .bus_last(bus_last),
    .bus_done(bus_done), .bus_nak(bus_nak), .bus_rdata(bus_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_raddr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  // driver side: expected operation and the response the bus model gives
  task automatic push_op(input logic [1:0] op, input logic [7:0] data, input logic last,
                         input logic nak, input logic [7:0] rdata);
    exp_q.push_back({op, last, data});
    rsp_q.push_back({nak, rdata});
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    int calm = 0;
    while (calm < 2) begin
      rd(2'd0, v);
      if (v[4:0] == 5'd0 && !bus_req) calm++;
      else calm = 0;
      repeat (8) @(negedge clk);
    end
  endtask

  task automatic chk_drained(input string tag);
    chk(tag, exp_q.size(), 0);
    while (exp_q.size() > 0) begin
      void'(exp_q.pop_front());
      void'(rsp_q.pop_front());
    end
  endtask

  // monitor and bus model: pop an expected item on each new request and compare
  initial begin
    forever begin
      @(negedge clk);
      if (bus_req) begin
        if (exp_q.size() == 0) begin
          chk("R3 unexpected bus op", {30'd0, bus_op}, 32'hFFFF_FFFF);
          rsp_q.push_back(9'd0);
        end else begin
          logic [10:0] e;
          e = exp_q.pop_front();
          chk("R3 bus op code", {30'd0, bus_op}, {30'd0, e[10:9]});
          chk("R4 bus write byte", {24'd0, bus_wdata}, {24'd0, e[7:0]});
          chk("R7 bus last flag", {31'd0, bus_last}, {31'd0, e[8]});
        end
        begin
          logic [8:0] r;
          r = rsp_q.pop_front();
          repeat (6) @(negedge clk);
          bus_done = 1'b1; bus_nak = r[8]; bus_rdata = r[7:0];
          @(negedge clk);
          bus_done = 1'b0; bus_nak = 1'b0;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk("R1 register reset value", v, 32'd0);
    end
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    chk("R1 no request after reset", {31'd0, bus_req}, 32'd0);

    // R2 upper half not writable; low half taken
    wr(2'd0, 32'hFFFF_0000);
    rd(2'd0, v);
    chk("R2 upper bits show state only", v, 32'd0);
    wr(2'd0, 32'h0000_A000);
    rd(2'd0, v);
    chk("R2 low half stored", v, 32'h0000_A000);
    wr(2'd0, 32'h0000_0000);

    // R4/R5 start with TX folded in, ack
    wr(2'd1, 32'h0000_00A4);
    push_op(2'd0, 8'hA4, 1'b0, 1'b0, 8'h00);
    wr(2'd0, 32'h0000_0003);
    repeat (2) @(negedge clk);
    rd(2'd0, v);
    chk("R4 plain start state", {29'd0, v[18:16]}, 32'd1);
    wait_idle();
    chk_drained("R4 start also covers tx");
    rd(2'd0, v);
    chk("R5 active after ack", v, 32'h0003_0000);
    rd(2'd3, v);
    chk("R5 txack set", v, 32'h1);

    // R9 write-one-to-clear
    wr(2'd3, 32'h0);
    rd(2'd3, v);
    chk("R9 zero write keeps bit", v, 32'h1);
    wr(2'd3, 32'h1);
    rd(2'd3, v);
    chk("R9 one write clears bit", v, 32'h0);

    // R6 tx ack
    wr(2'd1, 32'h0000_005A);
    push_op(2'd1, 8'h5A, 1'b0, 1'b0, 8'h00);
    wr(2'd0, 32'h0000_0002);
    wait_idle();
    chk_drained("R6 send issued");
    rd(2'd3, v);
    chk("R6 txack after send", v, 32'h1);
    rd(2'd0, v);
    chk("R6 back to active", {29'd0, v[18:16]}, 32'd3);
    wr(2'd3, 32'h1F);

    // R4 repeated start, then R7/R8 receive-last and stop
    wr(2'd1, 32'h0000_00A5);
    push_op(2'd0, 8'hA5, 1'b0, 1'b0, 8'h00);
    wr(2'd0, 32'h0000_0001);
    repeat (2) @(negedge clk);
    rd(2'd0, v);
    chk("R4 repeated start state", {29'd0, v[18:16]}, 32'd2);
    wait_idle();
    chk_drained("R4 repeated start op");
    push_op(2'd2, 8'h00, 1'b1, 1'b0, 8'h3C);
    push_op(2'd3, 8'h00, 1'b0, 1'b0, 8'h00);
    wr(2'd0, 32'h0000_0018);
    wait_idle();
    chk_drained("R8 receive then end");
    rd(2'd1, v);
    chk("R7 received byte in buffer", v, 32'h0000_3CA5);
    rd(2'd3, v);
    chk("R7 R8 rxdone and nstop", v, 32'h0000_000D);
    rd(2'd0, v);
    chk("R8 idle after stop", v, 32'd0);
    wr(2'd3, 32'h1F);

    // R3 full order in one command: start, receive, stop
    wr(2'd1, 32'h0000_00A1);
    push_op(2'd0, 8'hA1, 1'b0, 1'b0, 8'h00);
    push_op(2'd2, 8'h00, 1'b0, 1'b0, 8'h77);
    push_op(2'd3, 8'h00, 1'b0, 1'b0, 8'h00);
    wr(2'd0, 32'h0000_0015);
    wait_idle();
    chk_drained("R3 ordered phases");
    rd(2'd3, v);
    chk("R3 status after full command", v, 32'h0000_000D);

    // R7 receive stalls while RXDONE set; R2 write ignored while busy
    wr(2'd3, 32'h08);
    wr(2'd1, 32'h0000_00A1);
    push_op(2'd0, 8'hA1, 1'b0, 1'b0, 8'h00);
    wr(2'd0, 32'h0000_0015);
    repeat (40) @(negedge clk);
    chk_drained("R7 only start before stall");
    chk("R7 no request while stalled", {31'd0, bus_req}, 32'd0);
    rd(2'd0, v);
    chk("R7 rx and stop pending", v, 32'h0003_0014);
    wr(2'd0, 32'h0000_0010);
    rd(2'd0, v);
    chk("R2 write ignored while busy", v, 32'h0003_0014);
    push_op(2'd2, 8'h00, 1'b0, 1'b0, 8'h42);
    push_op(2'd3, 8'h00, 1'b0, 1'b0, 8'h00);
    wr(2'd3, 32'h05);
    wait_idle();
    chk_drained("R7 released after clear");
    rd(2'd1, v);
    chk("R7 second byte", v[15:8], 32'h42);
    wr(2'd3, 32'h1F);

    // R8 stop while idle
    wr(2'd0, 32'h0000_0010);
    wait_idle();
    chk_drained("R8 no op for idle stop");
    rd(2'd3, v);
    chk("R8 abnormal stop flag", v, 32'h10);

    // R10 interrupt masking
    wr(2'd2, 32'h10);
    repeat (2) @(negedge clk);
    chk("R10 irq enabled", {31'd0, irq}, 32'd1);
    wr(2'd2, 32'h0F);
    repeat (2) @(negedge clk);
    chk("R10 irq masked", {31'd0, irq}, 32'd0);
    wr(2'd2, 32'h0);
    wr(2'd3, 32'h1F);

    // R5 address refused abandons the rest
    wr(2'd1, 32'h0000_0090);
    push_op(2'd0, 8'h90, 1'b0, 1'b1, 8'h00);
    wr(2'd0, 32'h0000_0017);
    wait_idle();
    repeat (20) @(negedge clk);
    chk_drained("R5 nothing after refused address");
    rd(2'd3, v);
    chk("R5 txnak only", v, 32'h2);
    rd(2'd0, v);
    chk("R5 idle and cleared", v, 32'd0);
    wr(2'd3, 32'h1F);

    // R6 send refused: end op, no stop status
    wr(2'd1, 32'h0000_0090);
    push_op(2'd0, 8'h90, 1'b0, 1'b0, 8'h00);
    wr(2'd0, 32'h0000_0001);
    wait_idle();
    chk_drained("R6 setup start");
    wr(2'd3, 32'h1F);
    wr(2'd1, 32'h0000_00EE);
    push_op(2'd1, 8'hEE, 1'b0, 1'b1, 8'h00);
    push_op(2'd3, 8'h00, 1'b0, 1'b0, 8'h00);
    wr(2'd0, 32'h0000_0012);
    wait_idle();
    chk_drained("R6 refused send then end");
    rd(2'd3, v);
    chk("R6 txnak without stop flags", v, 32'h2);
    rd(2'd0, v);
    chk("R6 idle after refused send", v, 32'd0);
    wr(2'd3, 32'h1F);

    // R6 send with no active transfer
    wr(2'd0, 32'h0000_0002);
    wait_idle();
    chk_drained("R6 no op for idle send");
    rd(2'd3, v);
    chk("R6 idle send flags nak", v, 32'h2);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule